// File: doc/BRIEF.md
# Integer ALU with Operation Decode and Branch Evaluation

This block is the execute stage of a single-cycle 32-bit integer core with no state of its own. A decoder first turns four fields into a 4-bit operation code: a 2-bit instruction class from the main decoder, an immediate-form flag, the 7-bit upper function field and the 3-bit minor function field. A datapath then applies that operation to two operands.

Arithmetic, logic, shift and set-less-than operations return their full-width value. For conditional branches the datapath does the comparison itself and returns the taken/not-taken decision in bit 0, with every other bit cleared. The core uses that bit to choose the next program counter.

Width and shifter structure are parameters. The shifter is either a log-depth barrel network built stage by stage or a plain operator form.

Top module: `alu_branch_unit`

## Requirements
- R1: With class 00 (memory access) the operation code is 0010 and the result is opa + opb modulo 2^32, whatever the other fields hold.
- R2: With class 10 and the immediate flag clear, funct3 picks the code: 000 gives 0010 (add), or 0011 (sub) when funct7 bit 5 is set; 001 gives 1001 (sll); 010 gives 0110 (slt); 011 gives 0111 (sltu); 100 gives 0100 (xor); 101 gives 1010 (srl), or 1111 (sra) when funct7 bit 5 is set; 110 gives 0001 (or); 111 gives 0000 (and).
- R3: With class 10 and the immediate flag set, funct3 000 always gives 0010. Funct7 plays no part except bit 5 under funct3 101, which picks 1111 over 1010. All other funct3 values decode as in R2.
- R4: With class 01, funct3 selects the branch code: 000→1101 (equal), 001→1110 (not equal), 100→1000 (signed less), 101→1011 (signed greater-or-equal), 110→0101 (unsigned less), 111→1100 (unsigned greater-or-equal). Funct3 010 and 011 give 0000.
- R5: For the six branch codes, result bit 0 is 1 exactly when the condition holds, and bits 31..1 are 0.
- R6: Codes 1000, 1011 and 0110 compare the operands as two's-complement values. Codes 0101, 1100 and 0111 compare them as unsigned values.
- R7: The shift operations use only opb[4:0] as the shift amount. Code 1111 fills vacated bits with opa[31]; codes 1001 and 1010 fill them with 0.
- R8: Class 11 decodes to 0000 for every combination of the other fields.
- R9: Add and sub wrap modulo 2^32. Slt and sltu return 0 or 1 in bit 0 with upper bits 0. And, or and xor act bitwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 2 | Instruction class: 00 memory, 01 branch, 10 register/immediate arithmetic, 11 unused |
| itype_i | input | 1 | Immediate form; upper function bits belong to the immediate |
| funct7_i | input | 7 | Upper function field |
| funct3_i | input | 3 | Minor function field |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand or immediate |
| op_o | output | 4 | Decoded operation code |
| result_o | output | 32 | Operation result; bit 0 carries the branch decision |

## Verification
The embedded checks take for granted that every input carries a defined 0/1 value and that the inputs are settled before the outputs are judged. The block has no clock, so a check made while the decoder output lags an operand change would be meaningless. The stimulus changes all inputs together, waits half a clock period before sampling, and never leaves a field undriven. It covers the whole decode space, including the unused class and the two empty branch funct3 slots, so no input combination falls outside what the checks assume.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

   typedef enum logic [1:0] {
      CLS_MEM = 2'b00,
      CLS_BR  = 2'b01,
      CLS_REG = 2'b10,
      CLS_RSV = 2'b11
   } alu_class_e;

   typedef enum logic [3:0] {
      OP_AND  = 4'b0000,
      OP_OR   = 4'b0001,
      OP_ADD  = 4'b0010,
      OP_SUB  = 4'b0011,
      OP_XOR  = 4'b0100,
      OP_BLTU = 4'b0101,
      OP_SLT  = 4'b0110,
      OP_SLTU = 4'b0111,
      OP_BLT  = 4'b1000,
      OP_SLL  = 4'b1001,
      OP_SRL  = 4'b1010,
      OP_BGE  = 4'b1011,
      OP_BGEU = 4'b1100,
      OP_BEQ  = 4'b1101,
      OP_BNE  = 4'b1110,
      OP_SRA  = 4'b1111
   } alu_op_e;

   function automatic logic op_is_branch(alu_op_e op);
      return (op == OP_BEQ) || (op == OP_BNE) || (op == OP_BLT) ||
             (op == OP_BGE) || (op == OP_BLTU) || (op == OP_BGEU);
   endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_ctl_pkg::*;
(
   input  logic [1:0] cls_i,
   input  logic       itype_i,
   input  logic [6:0] funct7_i,
   input  logic [2:0] funct3_i,
   output alu_op_e    op_o
);

   localparam int ALT_BIT = 5;

   logic    alt_sel;
   alu_op_e br_op;
   alu_op_e reg_op;

   assign alt_sel = funct7_i[ALT_BIT];

   always_comb begin
      unique case (funct3_i)
         3'b000:  br_op = OP_BEQ;
         3'b001:  br_op = OP_BNE;
         3'b100:  br_op = OP_BLT;
         3'b101:  br_op = OP_BGE;
         3'b110:  br_op = OP_BLTU;
         3'b111:  br_op = OP_BGEU;
         default: br_op = OP_AND;
      endcase
   end

   always_comb begin
      unique case (funct3_i)
         3'b000:  reg_op = (alt_sel && !itype_i) ? OP_SUB : OP_ADD;
         3'b001:  reg_op = OP_SLL;
         3'b010:  reg_op = OP_SLT;
         3'b011:  reg_op = OP_SLTU;
         3'b100:  reg_op = OP_XOR;
         3'b101:  reg_op = alt_sel ? OP_SRA : OP_SRL;
         3'b110:  reg_op = OP_OR;
         default: reg_op = OP_AND;
      endcase
   end

   always_comb begin
      unique case (alu_class_e'(cls_i))
         CLS_MEM: op_o = OP_ADD;
         CLS_BR:  op_o = br_op;
         CLS_REG: op_o = reg_op;
         default: op_o = OP_AND;
      endcase
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] val_i,
   input  logic [SHW-1:0]  amt_i,
   input  logic            arith_i,
   output logic [XLEN-1:0] left_o,
   output logic [XLEN-1:0] right_o
);

   logic fill;
   assign fill = arith_i & val_i[XLEN-1];

   generate
      if (BARREL) begin : g_barrel
         logic [XLEN-1:0] lstg [SHW+1];
         logic [XLEN-1:0] rstg [SHW+1];
         assign lstg[0] = val_i;
         assign rstg[0] = val_i;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int DIST = 1 << k;
            assign lstg[k+1] = amt_i[k] ? {lstg[k][XLEN-DIST-1:0], {DIST{1'b0}}} : lstg[k];
            assign rstg[k+1] = amt_i[k] ? {{DIST{fill}}, rstg[k][XLEN-1:DIST]} : rstg[k];
         end
         assign left_o  = lstg[SHW];
         assign right_o = rstg[SHW];
      end else begin : g_plain
         logic [2*XLEN-1:0] wide;
         assign wide    = {{XLEN{fill}}, val_i} >> amt_i;
         assign left_o  = val_i << amt_i;
         assign right_o = wide[XLEN-1:0];
      end
   endgenerate

   always_comb begin
      // R7
      if (amt_i == '0) begin
         shift_zero_chk: assert (left_o == val_i && right_o == val_i);
      end
   end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o,
   output logic            lt_s_o,
   output logic            lt_u_o
);

   logic [XLEN:0] diff;
   logic          sign_differ;

   assign diff        = {1'b0, a_i} - {1'b0, b_i};
   assign eq_o        = (a_i == b_i);
   assign lt_u_o      = diff[XLEN];
   assign sign_differ = a_i[XLEN-1] ^ b_i[XLEN-1];
   assign lt_s_o      = sign_differ ? a_i[XLEN-1] : diff[XLEN];

   always_comb begin
      // R6
      if (eq_o) begin
         cmp_eq_not_less_chk: assert (!lt_u_o && !lt_s_o);
      end
   end

endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
   import alu_ctl_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic [1:0]      cls_i,
   input  logic            itype_i,
   input  logic [6:0]      funct7_i,
   input  logic [2:0]      funct3_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   output logic [3:0]      op_o,
   output logic [XLEN-1:0] result_o
);

   localparam int SHW = $clog2(XLEN);

   generate
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_width
         $error("alu_branch_unit: XLEN must be a power of two, at least 8");
      end
   endgenerate

   alu_op_e         op_w;
   logic [XLEN-1:0] sum_w;
   logic [XLEN-1:0] dif_w;
   logic [XLEN-1:0] shl_w;
   logic [XLEN-1:0] shr_w;
   logic            eq_w;
   logic            lt_s_w;
   logic            lt_u_w;
   logic            taken_w;

   alu_op_decode u_dec (
      .cls_i    (cls_i),
      .itype_i  (itype_i),
      .funct7_i (funct7_i),
      .funct3_i (funct3_i),
      .op_o     (op_w)
   );

   alu_shift #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .val_i   (opa_i),
      .amt_i   (opb_i[SHW-1:0]),
      .arith_i (op_w == OP_SRA),
      .left_o  (shl_w),
      .right_o (shr_w)
   );

   alu_compare #(.XLEN(XLEN)) u_cmp (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .eq_o   (eq_w),
      .lt_s_o (lt_s_w),
      .lt_u_o (lt_u_w)
   );

   assign sum_w = opa_i + opb_i;
   assign dif_w = opa_i - opb_i;
   assign op_o  = op_w;

   always_comb begin
      unique case (op_w)
         OP_BEQ:  taken_w = eq_w;
         OP_BNE:  taken_w = !eq_w;
         OP_BLT:  taken_w = lt_s_w;
         OP_BGE:  taken_w = !lt_s_w;
         OP_BLTU: taken_w = lt_u_w;
         OP_BGEU: taken_w = !lt_u_w;
         default: taken_w = 1'b0;
      endcase
   end

   always_comb begin
      unique case (op_w)
         OP_AND:  result_o = opa_i & opb_i;
         OP_OR:   result_o = opa_i | opb_i;
         OP_XOR:  result_o = opa_i ^ opb_i;
         OP_ADD:  result_o = sum_w;
         OP_SUB:  result_o = dif_w;
         OP_SLT:  result_o = {{(XLEN-1){1'b0}}, lt_s_w};
         OP_SLTU: result_o = {{(XLEN-1){1'b0}}, lt_u_w};
         OP_SLL:  result_o = shl_w;
         OP_SRL,
         OP_SRA:  result_o = shr_w;
         OP_BEQ, OP_BNE, OP_BLT,
         OP_BGE, OP_BLTU, OP_BGEU:
                  result_o = {{(XLEN-1){1'b0}}, taken_w};
         default: result_o = '0;
      endcase
   end

   always_comb begin
      // R1
      if (cls_i == 2'b00) begin
         ldst_add_chk: assert (op_w == OP_ADD && result_o == opa_i + opb_i);
      end
      // R3
      if (cls_i == 2'b10 && itype_i && funct3_i == 3'b000) begin
         itype_nosub_chk: assert (op_w == OP_ADD);
      end
      // R5
      if (op_is_branch(op_w)) begin
         br_upper_zero_chk: assert (result_o[XLEN-1:1] == '0);
      end
      // R5
      if (op_w == OP_BEQ && opa_i == opb_i) begin
         beq_taken_chk: assert (result_o[0]);
      end
      // R8
      if (cls_i == 2'b11) begin
         rsv_class_chk: assert (op_w == OP_AND);
      end
   end

endmodule

// File: tb/alu_branch_unit_test.sv
module alu_branch_unit_test;

   localparam real HALF = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cls;
   logic        itype;
   logic [6:0]  f7;
   logic [2:0]  f3;
   logic [31:0] a;
   logic [31:0] b;
   logic [3:0]  op;
   logic [31:0] res;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(HALF) clk = ~clk;

   alu_branch_unit uut (
      .cls_i    (cls),
      .itype_i  (itype),
      .funct7_i (f7),
      .funct3_i (f3),
      .opa_i    (a),
      .opb_i    (b),
      .op_o     (op),
      .result_o (res)
   );

   function automatic logic [3:0] exp_op(logic [1:0] c, logic it, logic [6:0] g7, logic [2:0] g3);
      if (c == 2'b00) return 4'b0010;
      if (c == 2'b11) return 4'b0000;
      if (c == 2'b01) begin
         case (g3)
            3'b000: return 4'b1101;
            3'b001: return 4'b1110;
            3'b100: return 4'b1000;
            3'b101: return 4'b1011;
            3'b110: return 4'b0101;
            3'b111: return 4'b1100;
            default: return 4'b0000;
         endcase
      end
      case (g3)
         3'b000: return (!it && g7[5]) ? 4'b0011 : 4'b0010;
         3'b001: return 4'b1001;
         3'b010: return 4'b0110;
         3'b011: return 4'b0111;
         3'b100: return 4'b0100;
         3'b101: return g7[5] ? 4'b1111 : 4'b1010;
         3'b110: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [31:0] exp_res(logic [3:0] o, logic [31:0] x, logic [31:0] y);
      int sh = int'(y[4:0]);
      logic slt  = $signed(x) < $signed(y);
      logic sltu = x < y;
      case (o)
         4'b0000: return x & y;
         4'b0001: return x | y;
         4'b0010: return x + y;
         4'b0011: return x - y;
         4'b0100: return x ^ y;
         4'b0110: return {31'd0, slt};
         4'b0111: return {31'd0, sltu};
         4'b1001: return x << sh;
         4'b1010: return x >> sh;
         4'b1111: return 32'($signed(x) >>> sh);
         4'b1101: return {31'd0, x == y};
         4'b1110: return {31'd0, x != y};
         4'b1000: return {31'd0, slt};
         4'b1011: return {31'd0, !slt};
         4'b0101: return {31'd0, sltu};
         default: return {31'd0, !sltu};
      endcase
   endfunction

   function automatic string req_of(logic [1:0] c, logic it);
      if (c == 2'b00) return "R1";
      if (c == 2'b01) return "R4";
      if (c == 2'b11) return "R8";
      return it ? "R3" : "R2";
   endfunction

   function automatic string res_req(logic [3:0] o);
      case (o)
         4'b1101, 4'b1110: return "R5";
         4'b1000, 4'b1011, 4'b0101, 4'b1100, 4'b0110, 4'b0111: return "R6";
         4'b1001, 4'b1010, 4'b1111: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] expv);
      checks++;
      if (got !== expv) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h (cls=%b it=%b f7=%b f3=%b a=%h b=%h)",
                  req, what, got, expv, cls, itype, f7, f3, a, b);
      end
   endtask

   task automatic apply(logic [1:0] c, logic it, logic [6:0] g7, logic [2:0] g3,
                        logic [31:0] x, logic [31:0] y);
      @(posedge clk);
      cls = c; itype = it; f7 = g7; f3 = g3; a = x; b = y;
      @(negedge clk);
   endtask

   logic [31:0] corner [8];

   initial begin
      corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
      corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
      corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h0000_0021;
      corner[6] = 32'h0000_001F; corner[7] = 32'h1234_5678;
      cls = '0; itype = 1'b0; f7 = '0; f3 = '0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state with all-zero inputs
      check("R1", "idle op", {28'd0, op}, 32'h2);
      check("R1", "idle result", res, 32'h0);

      // Decode sweep over every field combination (R1 R2 R3 R4 R8)
      for (int c = 0; c < 4; c++)
         for (int it = 0; it < 2; it++)
            for (int g3 = 0; g3 < 8; g3++)
               for (int g7 = 0; g7 < 128; g7++) begin
                  apply(2'(c), 1'(it), 7'(g7), 3'(g3), 32'h0000_0005, 32'h0000_0003);
                  check(req_of(2'(c), 1'(it)), "op", {28'd0, op},
                        {28'd0, exp_op(2'(c), 1'(it), 7'(g7), 3'(g3))});
               end

      // Result sweep on signed/unsigned boundary operands (R5 R6 R7 R9)
      for (int c = 0; c < 4; c++)
         for (int it = 0; it < 2; it++)
            for (int g3 = 0; g3 < 8; g3++)
               for (int alt = 0; alt < 2; alt++)
                  for (int i = 0; i < 8; i++)
                     for (int j = 0; j < 8; j++) begin
                        logic [3:0] eo;
                        eo = exp_op(2'(c), 1'(it), alt ? 7'h20 : 7'h00, 3'(g3));
                        apply(2'(c), 1'(it), alt ? 7'h20 : 7'h00, 3'(g3), corner[i], corner[j]);
                        check(res_req(eo), "result", res, exp_res(eo, corner[i], corner[j]));
                     end

      // Random operands through every register and branch slot (R5 R6 R7 R9)
      for (int n = 0; n < 300; n++) begin
         logic [31:0] x;
         logic [31:0] y;
         logic [2:0]  g3;
         logic [1:0]  c;
         logic [3:0]  eo;
         x  = $urandom;
         y  = (n % 3 == 0) ? x : $urandom;
         g3 = 3'($urandom);
         c  = (n % 2 == 0) ? 2'b01 : 2'b10;
         eo = exp_op(c, 1'b0, 7'(n[0] ? 7'h20 : 7'h00), g3);
         apply(c, 1'b0, 7'(n[0] ? 7'h20 : 7'h00), g3, x, y);
         check(res_req(eo), "random result", res, exp_res(eo, x, y));
      end

      // R7: shift amount above 31 uses only the low five bits
      apply(2'b10, 1'b1, 7'h20, 3'b101, 32'h8000_0000, 32'hFFFF_FFE4);
      check("R7", "sra by 4 from wide amount", res, 32'hF800_0000);
      // R3: immediate form never subtracts
      apply(2'b10, 1'b1, 7'h7F, 3'b000, 32'd10, 32'd3);
      check("R3", "itype add", res, 32'd13);
      // R6: signed versus unsigned ordering at the sign boundary
      apply(2'b01, 1'b0, 7'h00, 3'b100, 32'h8000_0000, 32'h7FFF_FFFF);
      check("R6", "blt signed", res, 32'd1);
      apply(2'b01, 1'b0, 7'h00, 3'b110, 32'h8000_0000, 32'h7FFF_FFFF);
      check("R6", "bltu unsigned", res, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule